// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end of a register bank. An SPI master selects it by pulling chip select low, then clocks in a 16-bit command word, most significant bit first. The command holds a fixed 5-bit key, a direction flag and a 10-bit start address. After the command the master moves 16-bit data words in a burst. The block advances its address pointer after every complete word. The pointer stops at a top address and does not wrap.

On the parallel side the block drives a synchronous register-file port: an address, write data and a one-cycle write strobe. A read-data input returns the word at the presented address in the same cycle. The serial pins are sampled with the system clock through synchronizers, so every register update happens in the system clock domain.

The controller is a state machine with six states:
- Idle: chip select is high.
- Command: the command word is being collected.
- Write: data words are being stored.
- Read: data words are being shifted out.
- Rejected: the key was wrong.
- Saturated: the top address has been passed.

Its transitions are:
- Idle to Command when chip select falls.
- Command to Rejected on a bad key.
- Command to Saturated when the start address is above the top.
- Command to Write or to Read when the key is good, according to the flag.
- Write or Read to Saturated after the word at the top address.
- Any state to Idle when chip select rises.

Top module: `spireg_slave`

## Requirements
- R1: A transaction starts when chip select falls. The first 16 SDI bits, sampled on SCLK rising edges and taken MSB first, form the command word.
- R2: Command bits [15:11] must equal 11100. Any other value gives no register write and keeps `spi_sdo_oe` low until chip select rises.
- R3: Command bit 10 sets the direction: 1 is a read burst and 0 is a write burst. During a write burst `spi_sdo_oe` stays low.
- R4: Command bits [9:0] are the first register address. Each complete 16-bit data word after the command gives one `rf_we` pulse, with `rf_addr` equal to the pointer and `rf_wdata` equal to the word taken MSB first.
- R5: After each complete data word the pointer increases by one, so consecutive words go to or come from consecutive registers.
- R6: The word at `TOP_ADDR` is still transferred. After it, write data is ignored and `spi_sdo_oe` drops. A start address above `TOP_ADDR` gives no transfer at all.
- R7: If chip select rises in the middle of a word, that partial word is discarded and produces no write. The next transaction starts from bit zero.
- R8: In a read burst, SDO changes only after SCLK falling edges. It shifts out the register words MSB first, starting at the command address. `spi_sdo_oe` is high from the command's end until chip select rises.
- R9: SCLK may idle either high or low while chip select is high, with the same results.
- R10: After reset the block is in Idle, with `spi_sdo_oe` low and no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_oe | output | 1 | Drive enable for SDO; high-impedance when low |
| rf_addr | output | ADDR_W | Register-file address (burst pointer) |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_we | output | 1 | One-cycle register-file write strobe |
| rf_rdata | input | DATA_W | Register-file read data for `rf_addr` |

## Verification
The bench builds the block with `TOP_ADDR` set to 12 and keeps the 16-bit word and 10-bit address field. With that setting, the top address and the start-above-top case can be reached with bursts of a few words. Every one of the 32 key values is swept in both directions against a register-file model held in the bench. Bursts that cross the top address, chip select rises part-way through a word, and both SCLK idle levels are checked against expected contents computed arithmetically.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_REJECT,
        ST_SATURATED
    } spireg_state_e;

    localparam logic [4:0] CMD_KEY = 5'b11100;

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= {STAGES{RST_VAL[gi]}};
            end else begin
                pipe <= {pipe[STAGES-2:0], d[gi]};
            end
        end

        assign q[gi] = pipe[STAGES-1];
    end

endmodule

// File: rtl/spireg_rx.sv
module spireg_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         word_done
);

    localparam int              CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     sreg;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sreg   <= '0;
            done_q <= 1'b0;
        end else if (clear) begin
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (shift_en) begin
            sreg   <= {sreg[W-2:0], bit_in};
            done_q <= (cnt == LAST);
            cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    assign word      = sreg;
    assign word_done = done_q;

    // Each completed word is reported for exactly one cycle (R5)
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    // A cleared counter never reports a finished word (R7)
    assert_clear_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !word_done);

endmodule

// File: rtl/spireg_tx.sv
module spireg_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_word,
    output logic         msb
);

    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_word;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign msb = sreg[W-1];

    // Loading and shifting come from distinct falling-edge slots (R8)
    assert_load_shift_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int TOP_ADDR    = (1 << ADDR_W) - 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    input  logic [DATA_W-1:0] rf_rdata
);

    localparam int               KEY_LSB = DATA_W - 5;
    localparam int               RW_BIT  = DATA_W - 6;
    localparam logic [ADDR_W-1:0] TOP_L  = ADDR_W'(TOP_ADDR);

    // ---------------- input synchronisation and edges ----------------
    logic [2:0] pins_s;
    logic       s_sclk, s_cs_n, s_sdi;
    logic       sclk_d;
    logic       sclk_rise, sclk_fall, cs_active;

    spireg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sdi, spi_cs_n, spi_sclk}),
        .q     (pins_s)
    );

    assign s_sclk = pins_s[0];
    assign s_cs_n = pins_s[1];
    assign s_sdi  = pins_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= s_sclk;
        end
    end

    assign sclk_rise = s_sclk & ~sclk_d;
    assign sclk_fall = ~s_sclk & sclk_d;
    assign cs_active = ~s_cs_n;

    // ---------------- word receiver ----------------
    logic [DATA_W-1:0] rx_word;
    logic              rx_done;

    spireg_rx #(.W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (~cs_active),
        .shift_en  (cs_active & sclk_rise),
        .bit_in    (s_sdi),
        .word      (rx_word),
        .word_done (rx_done)
    );

    logic [4:0]        cmd_key;
    logic              cmd_rd;
    logic [ADDR_W-1:0] cmd_addr;

    assign cmd_key  = rx_word[DATA_W-1:KEY_LSB];
    assign cmd_rd   = rx_word[RW_BIT];
    assign cmd_addr = rx_word[ADDR_W-1:0];

    // ---------------- state machine ----------------
    spireg_state_e     state, state_nxt;
    logic [ADDR_W-1:0] ptr;
    logic              at_top;
    logic              load_pend;
    logic              tx_load, tx_shift, tx_msb;

    assign at_top = (ptr == TOP_L);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (!cs_active) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_CMD;
                ST_CMD: begin
                    if (rx_done) begin
                        if (cmd_key != CMD_KEY) begin
                            state_nxt = ST_REJECT;
                        end else if (cmd_addr > TOP_L) begin
                            state_nxt = ST_SATURATED;
                        end else if (cmd_rd) begin
                            state_nxt = ST_READ;
                        end else begin
                            state_nxt = ST_WRITE;
                        end
                    end
                end
                ST_WRITE, ST_READ: begin
                    if (rx_done && at_top) begin
                        state_nxt = ST_SATURATED;
                    end
                end
                ST_REJECT, ST_SATURATED: state_nxt = state;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- burst pointer and read-load pending flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            load_pend <= 1'b0;
        end else if (!cs_active) begin
            load_pend <= 1'b0;
        end else begin
            if (state == ST_CMD && rx_done) begin
                ptr       <= cmd_addr;
                load_pend <= 1'b1;
            end else if ((state == ST_WRITE || state == ST_READ) && rx_done) begin
                if (!at_top) begin
                    ptr <= ptr + 1'b1;
                end
                load_pend <= 1'b1;
            end else if (tx_load) begin
                load_pend <= 1'b0;
            end
        end
    end

    assign tx_load  = (state == ST_READ) && sclk_fall && load_pend;
    assign tx_shift = (state == ST_READ) && sclk_fall && !load_pend;

    spireg_tx #(.W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .shift     (tx_shift),
        .load_word (rf_rdata),
        .msb       (tx_msb)
    );

    // ---------------- outputs ----------------
    always_comb begin
        rf_addr    = ptr;
        rf_wdata   = rx_word;
        rf_we      = 1'b0;
        spi_sdo_oe = 1'b0;
        spi_sdo    = tx_msb;
        unique case (state)
            ST_WRITE: rf_we = rx_done;
            ST_READ:  spi_sdo_oe = 1'b1;
            ST_IDLE, ST_CMD, ST_REJECT, ST_SATURATED: ;
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT) |-> (!rf_we && !spi_sdo_oe));

    assert_oe_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sdo_oe) |-> $past(state) == ST_CMD);

    assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE || state == ST_READ) |-> (ptr <= TOP_L));

    assert_we_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> cs_active);

    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !spi_sdo_oe);

endmodule

// File: tb/spireg_slave_tb.sv
module spireg_slave_tb;

    localparam int DW   = 16;
    localparam int AW   = 10;
    localparam int TOP  = 12;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic          cs_n = 1'b1;
    logic          sdi = 1'b0;
    logic          sdo, sdo_oe, rf_we;
    logic [AW-1:0] rf_addr;
    logic [DW-1:0] rf_wdata, rf_rdata;

    always #4 clk = ~clk;

    spireg_slave #(
        .DATA_W   (DW),
        .ADDR_W   (AW),
        .TOP_ADDR (TOP)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_cs_n   (cs_n),
        .spi_sdi    (sdi),
        .spi_sdo    (sdo),
        .spi_sdo_oe (sdo_oe),
        .rf_addr    (rf_addr),
        .rf_wdata   (rf_wdata),
        .rf_we      (rf_we),
        .rf_rdata   (rf_rdata)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'hC35A ^ 16'(i * 331);
    endfunction

    // Register-file model outside the block
    logic [15:0] mem [0:1023];
    int          wr_count;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
            wr_count <= 0;
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            wr_count     <= wr_count + 1;
        end
    end
    assign rf_rdata = mem[rf_addr];

    logic [15:0] expm [0:1023];
    int          exp_wr;
    int          checks = 0;
    int          fails  = 0;

    logic [15:0] txw  [0:7];
    logic [15:0] rxw  [0:7];
    logic        rxoe [0:7];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] mk_cmd(input logic [4:0] key, input logic rd, input int addr);
        return {key, rd, 10'(addr)};
    endfunction

    task automatic spi_txn(input bit idle_hi, input int nbits);
        for (int k = 0; k < 8; k++) begin
            rxw[k]  = '0;
            rxoe[k] = 1'b0;
        end
        @(negedge clk);
        sclk = idle_hi;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi  = txw[i / 16][15 - (i % 16)];
            repeat (HALF) @(negedge clk);
            rxw[i / 16]  = {rxw[i / 16][14:0], sdo};
            rxoe[i / 16] = rxoe[i / 16] | sdo_oe;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        sclk = idle_hi;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) expm[i] = init_val(i);
        exp_wr = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        chk(sdo_oe == 1'b0, "R10 oe after reset", 32'(sdo_oe), 0);
        chk(rf_we == 1'b0, "R10 we after reset", 32'(rf_we), 0);
        chk(wr_count == 0, "R10 no writes after reset", wr_count, 0);

        // R2/R3/R4/R1: sweep every key value with write commands
        for (int key = 0; key < 32; key++) begin
            int a = key % 8;
            txw[0] = mk_cmd(5'(key), 1'b0, a);
            txw[1] = 16'h1000 + 16'(key * 257);
            spi_txn(key[0], 32);
            if (key == 5'b11100) begin
                expm[a] = txw[1];
                exp_wr++;
            end
            chk(wr_count == exp_wr, "R2 write count after key sweep", wr_count, exp_wr);
            chk(mem[a] == expm[a], "R4 register after keyed write", mem[a], expm[a]);
            chk(rxoe[1] == 1'b0, "R3 sdo released during write", 32'(rxoe[1]), 0);
        end

        // R2/R8: sweep every key value with read commands
        for (int key = 0; key < 32; key++) begin
            int a = 4 + key % 8;
            txw[0] = mk_cmd(5'(key), 1'b1, a);
            txw[1] = 16'hFFFF;
            spi_txn(key[1], 32);
            if (key == 5'b11100) begin
                chk(rxoe[1] == 1'b1, "R8 oe during valid read", 32'(rxoe[1]), 1);
                chk(rxw[1] == expm[a], "R8 read word", rxw[1], expm[a]);
            end else begin
                chk(rxoe[1] == 1'b0, "R2 oe low on bad key", 32'(rxoe[1]), 0);
            end
            chk(rxoe[0] == 1'b0, "R3 oe low during command", 32'(rxoe[0]), 0);
            chk(wr_count == exp_wr, "R3 read makes no writes", wr_count, exp_wr);
        end

        // R1: MSB-first address field, address 9
        txw[0] = mk_cmd(5'b11100, 1'b0, 9);
        txw[1] = 16'h8001;
        spi_txn(1'b0, 32);
        expm[9] = 16'h8001; exp_wr++;
        chk(mem[9] == 16'h8001, "R1 MSB-first command and data", mem[9], 16'h8001);

        // R5: write burst of four words from address 3
        txw[0] = mk_cmd(5'b11100, 1'b0, 3);
        for (int k = 1; k <= 4; k++) txw[k] = 16'hB000 + 16'(k * 17);
        spi_txn(1'b0, 80);
        for (int k = 1; k <= 4; k++) begin
            expm[2 + k] = txw[k];
            exp_wr++;
        end
        for (int k = 3; k <= 7; k++)
            chk(mem[k] == expm[k], "R5 burst write contents", mem[k], expm[k]);
        chk(wr_count == exp_wr, "R5 burst write count", wr_count, exp_wr);

        // R5/R9: read burst of five words from address 2, SCLK idling high
        txw[0] = mk_cmd(5'b11100, 1'b1, 2);
        for (int k = 1; k <= 5; k++) txw[k] = '0;
        spi_txn(1'b1, 96);
        for (int k = 1; k <= 5; k++)
            chk(rxw[k] == expm[1 + k], "R5 R9 burst read word", rxw[k], expm[1 + k]);

        // R9: same read with SCLK idling low
        spi_txn(1'b0, 96);
        for (int k = 1; k <= 5; k++)
            chk(rxw[k] == expm[1 + k], "R9 idle-low burst read word", rxw[k], expm[1 + k]);

        // R6: write burst crossing the top address
        txw[0] = mk_cmd(5'b11100, 1'b0, TOP - 1);
        for (int k = 1; k <= 4; k++) txw[k] = 16'h5A00 + 16'(k);
        spi_txn(1'b0, 80);
        expm[TOP - 1] = txw[1];
        expm[TOP]     = txw[2];
        exp_wr += 2;
        chk(mem[TOP - 1] == expm[TOP - 1], "R6 write below top", mem[TOP - 1], expm[TOP - 1]);
        chk(mem[TOP] == expm[TOP], "R6 write at top", mem[TOP], expm[TOP]);
        chk(mem[TOP + 1] == expm[TOP + 1], "R6 no write past top", mem[TOP + 1], expm[TOP + 1]);
        chk(wr_count == exp_wr, "R6 saturated write count", wr_count, exp_wr);

        // R6: read burst from the top address
        txw[0] = mk_cmd(5'b11100, 1'b1, TOP);
        spi_txn(1'b1, 64);
        chk(rxw[1] == expm[TOP], "R6 read at top", rxw[1], expm[TOP]);
        chk(rxoe[1] == 1'b1, "R6 oe on top word", 32'(rxoe[1]), 1);
        chk(rxoe[2] == 1'b0, "R6 oe released past top", 32'(rxoe[2]), 0);
        chk(rxoe[3] == 1'b0, "R6 oe stays released", 32'(rxoe[3]), 0);

        // R6: start address above the top
        txw[0] = mk_cmd(5'b11100, 1'b0, 40);
        txw[1] = 16'h7777;
        spi_txn(1'b0, 32);
        chk(wr_count == exp_wr, "R6 start above top no write", wr_count, exp_wr);
        chk(mem[40] == expm[40], "R6 start above top contents", mem[40], expm[40]);
        txw[0] = mk_cmd(5'b11100, 1'b1, 40);
        spi_txn(1'b0, 32);
        chk(rxoe[1] == 1'b0, "R6 read above top released", 32'(rxoe[1]), 0);

        // R7: chip select rises part-way through the first data word
        txw[0] = mk_cmd(5'b11100, 1'b0, 5);
        txw[1] = 16'h1234;
        spi_txn(1'b0, 26);
        chk(wr_count == exp_wr, "R7 partial word no write", wr_count, exp_wr);
        chk(mem[5] == expm[5], "R7 partial word contents", mem[5], expm[5]);

        // R7: one full word then a partial one
        txw[1] = 16'h4321;
        txw[2] = 16'hFFFF;
        spi_txn(1'b1, 39);
        expm[5] = 16'h4321; exp_wr++;
        chk(wr_count == exp_wr, "R7 full plus partial count", wr_count, exp_wr);
        chk(mem[5] == expm[5], "R7 full word kept", mem[5], expm[5]);
        chk(mem[6] == expm[6], "R7 partial word dropped", mem[6], expm[6]);

        // R7: next transaction starts cleanly
        txw[0] = mk_cmd(5'b11100, 1'b0, 6);
        txw[1] = 16'h0F0F;
        spi_txn(1'b0, 32);
        expm[6] = 16'h0F0F; exp_wr++;
        chk(mem[6] == expm[6], "R7 clean restart write", mem[6], expm[6]);
        chk(wr_count == exp_wr, "R7 clean restart count", wr_count, exp_wr);

        // R10: idle again
        chk(sdo_oe == 1'b0, "R10 oe released when idle", 32'(sdo_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule